// File: doc/BRIEF.md
# AMI Line Violation and Carrier-Loss Monitor

This block sits at the receive edge of a T1 line interface. The positive and negative rails of the alternate-mark-inversion signal come in on two pins. The block samples both rails on the falling edge of the receive clock and merges them into a single NRZ bit stream, which it updates on the following rising edge. It also watches the polarity of successive marks and raises a violation flag when two marks in a row have the same polarity. The flag sits in the same output bit time as the offending mark.

A carrier-loss flag rises after a long run of bit times in which neither rail carries a mark. It drops as soon as a mark arrives. To feed the block with plain NRZ data, drive the same signal onto both rails. A bit time with both rails high is taken as an NRZ one. It never counts as a violation, and it clears the polarity memory, so violation checking stays silent for a tied input.

Top module: `ami_line_monitor`

## Requirements
- R1: Rail inputs are sampled only at the falling clock edge. Rail changes made after a falling edge and undone before the next falling edge have no effect on any output.
- R2: A bit sampled at a falling edge appears on `nrz_data` at the next rising edge, as the OR of the two rails (1 = mark, 0 = space). It is held for one full clock period.
- R3: A single-rail mark with the same polarity as the most recent single-rail mark raises `bpv_flag` for that bit's output period only. Positive means `rail_p`=1 and `rail_n`=0; negative means `rail_p`=0 and `rail_n`=1.
- R4: Marks of alternating polarity never raise `bpv_flag`, whatever number of spaces lie between them. Spaces neither change nor clear the polarity memory.
- R5: A bit time with both rails high outputs a one and never raises `bpv_flag`. It clears the polarity memory, so the next single-rail mark is not a violation. With the rails tied together, `bpv_flag` therefore stays low.
- R6: `los_flag` rises in the output period of the 32nd consecutive space (parameter `LOS_ZEROS`). It stays high while spaces continue.
- R7: `los_flag` falls in the output period of the first mark after carrier loss, and it is never high together with `nrz_data`.
- R8: A run of 31 spaces followed by a mark never raises `los_flag`.
- R9: Synchronous active-high reset clears all three outputs, the polarity memory and the space counter. The first mark after reset is not a violation, and the space count restarts from zero.
- R10: `bpv_flag` is high only in a period in which `nrz_data` is high. It has the same latency as the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock; rails sampled on its falling edge, outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rail_p | input | 1 | Positive-pulse rail of the line |
| rail_n | input | 1 | Negative-pulse rail of the line |
| nrz_data | output | 1 | Merged NRZ bit stream |
| bpv_flag | output | 1 | High during the output period of a bipolar violation |
| los_flag | output | 1 | High while carrier is considered lost |

## Verification
Carrier loss is the state that is hardest to reach from the ports: random bits almost never give 32 spaces in a row. The stimulus therefore includes phases in which marks are sparse, plus directed runs of exactly 31 and 32 spaces. The falling-edge sampling rule is checked by corrupting the rails after each sampling edge and restoring them before the next, so that only a design that samples at the correct edge keeps its output right. A tied-rail phase and a reset in the middle of a run cover the polarity-memory clear paths.

// File: rtl/ami_mon_pkg.sv
package ami_mon_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } mark_pol_t;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_POS   = 2'd1,
        SYM_NEG   = 2'd2,
        SYM_DUAL  = 2'd3
    } sym_kind_t;

    function automatic sym_kind_t classify(input rail_pair_t r);
        sym_kind_t k;
        case ({r.pos, r.neg})
            2'b10:   k = SYM_POS;
            2'b01:   k = SYM_NEG;
            2'b11:   k = SYM_DUAL;
            default: k = SYM_SPACE;
        endcase
        return k;
    endfunction

    function automatic logic is_violation(input sym_kind_t s, input mark_pol_t last);
        return ((s == SYM_POS) && (last == POL_POS)) ||
               ((s == SYM_NEG) && (last == POL_NEG));
    endfunction

    function automatic mark_pol_t next_pol(input sym_kind_t s, input mark_pol_t last);
        mark_pol_t n;
        case (s)
            SYM_POS:  n = POL_POS;
            SYM_NEG:  n = POL_NEG;
            SYM_DUAL: n = POL_NONE;
            default:  n = last;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ami_rail_capture.sv
module ami_rail_capture
    import ami_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rail_p,
    input  logic       rail_n,
    output rail_pair_t cap
);

    // Rails are sampled on the falling edge, half a period before outputs move.
    always_ff @(negedge clk) begin
        if (rst) begin
            cap <= '0;
        end else begin
            cap.pos <= rail_p;
            cap.neg <= rail_n;
        end
    end

endmodule

// File: rtl/ami_decoder.sv
module ami_decoder
    import ami_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rail_pair_t cap,
    output logic       nrz_q,
    output logic       bpv_q
);

    mark_pol_t last_pol;
    sym_kind_t sym;
    logic      viol;

    always_comb begin
        sym  = classify(cap);
        viol = is_violation(sym, last_pol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nrz_q    <= 1'b0;
            bpv_q    <= 1'b0;
            last_pol <= POL_NONE;
        end else begin
            nrz_q    <= (sym != SYM_SPACE);
            bpv_q    <= viol;
            last_pol <= next_pol(sym, last_pol);
        end
    end

    // A doubled mark is read as an NRZ one and is never accused.
    assert_dual_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (cap.pos && cap.neg) |=> (nrz_q && !bpv_q));

    // A repeated positive mark must be accused in its output period.
    assert_repeat_pos_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (cap.pos && !cap.neg && last_pol == POL_POS) |=> bpv_q);

    // A repeated negative mark must be accused in its output period.
    assert_repeat_neg_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!cap.pos && cap.neg && last_pol == POL_NEG) |=> bpv_q);

    // A space gives a zero on the data output and no flag.
    assert_space_output_R2: assert property (@(posedge clk) disable iff (rst)
        (!cap.pos && !cap.neg) |=> (!nrz_q && !bpv_q));

endmodule

// File: rtl/ami_carrier_monitor.sv
module ami_carrier_monitor
    import ami_mon_pkg::*;
#(
    parameter int LOS_ZEROS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  rail_pair_t cap,
    output logic       los_q
);

    localparam int                CNT_W    = $clog2(LOS_ZEROS + 1);
    localparam logic [CNT_W-1:0]  RUN_MAX  = CNT_W'(LOS_ZEROS);
    localparam logic [CNT_W-1:0]  RUN_LAST = CNT_W'(LOS_ZEROS - 1);

    logic [CNT_W-1:0] space_run;
    logic             mark_seen;

    assign mark_seen = cap.pos | cap.neg;

    always_ff @(posedge clk) begin
        if (rst) begin
            space_run <= '0;
            los_q     <= 1'b0;
        end else if (mark_seen) begin
            space_run <= '0;
            los_q     <= 1'b0;
        end else begin
            if (space_run != RUN_MAX) begin
                space_run <= space_run + 1'b1;
            end
            los_q <= (space_run >= RUN_LAST);
        end
    end

    // Loss is only entered once the full run of spaces has been counted.
    assert_los_needs_full_run_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(los_q) |-> (space_run == RUN_MAX));

    // Any mark drops the loss flag in its own output period.
    assert_mark_clears_los_R7: assert property (@(posedge clk) disable iff (rst)
        mark_seen |=> !los_q);

endmodule

// File: rtl/ami_line_monitor.sv
module ami_line_monitor
    import ami_mon_pkg::*;
#(
    parameter int LOS_ZEROS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_p,
    input  logic rail_n,
    output logic nrz_data,
    output logic bpv_flag,
    output logic los_flag
);

    rail_pair_t cap;

    ami_rail_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .rail_p (rail_p),
        .rail_n (rail_n),
        .cap    (cap)
    );

    ami_decoder u_decoder (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .nrz_q (nrz_data),
        .bpv_q (bpv_flag)
    );

    ami_carrier_monitor #(
        .LOS_ZEROS (LOS_ZEROS)
    ) u_carrier (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .los_q (los_flag)
    );

    // The violation flag travels with its data bit.
    assert_bpv_with_mark_R10: assert property (@(posedge clk) disable iff (rst)
        bpv_flag |-> nrz_data);

    // Carrier loss and a mark never share an output period.
    assert_los_excludes_mark_R7: assert property (@(posedge clk) disable iff (rst)
        los_flag |-> !nrz_data);

endmodule

// File: tb/ami_line_monitor_test.sv
module ami_line_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int LOS_N      = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_p = 1'b0;
    logic rail_n = 1'b0;
    logic nrz_data, bpv_flag, los_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state held by the bench
    int m_last = 0;   // 0 none, 1 positive, 2 negative
    int m_run  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ami_line_monitor #(.LOS_ZEROS(LOS_N)) uut (
        .clk      (clk),
        .rst      (rst),
        .rail_p   (rail_p),
        .rail_n   (rail_n),
        .nrz_data (nrz_data),
        .bpv_flag (bpv_flag),
        .los_flag (los_flag)
    );

    function automatic logic exp_bpv_of(input logic p, input logic n, input int last);
        return (p && !n && last == 1) || (!p && n && last == 2);
    endfunction

    function automatic int next_last(input logic p, input logic n, input int last);
        if (p && n) return 0;
        if (p)      return 1;
        if (n)      return 2;
        return last;
    endfunction

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Called at rising edge + 2; drives one bit, optionally corrupts the rails
    // after the sampling edge, then checks the outputs one period later.
    task automatic step(input logic p, input logic n, input string req, input bit glitch);
        logic e_nrz, e_bpv, e_los;
        rail_p = p;
        rail_n = n;
        e_nrz  = p | n;
        e_bpv  = exp_bpv_of(p, n, m_last);
        m_last = next_last(p, n, m_last);
        if (e_nrz) m_run = 0; else m_run++;
        e_los  = (m_run >= LOS_N);
        if (glitch) begin
            @(negedge clk); #2;
            rail_p = ~p;
            rail_n = $urandom_range(0, 1) != 0;
        end
        @(posedge clk); #2;
        check1(req, "nrz_data R2", nrz_data, e_nrz);
        check1(req, "bpv_flag R3 R10", bpv_flag, e_bpv);
        check1(req, "los_flag R6", los_flag, e_los);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rail_p = 1'b0;
        rail_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check1("R9", "nrz_data", nrz_data, 1'b0);
        check1("R9", "bpv_flag", bpv_flag, 1'b0);
        check1("R9", "los_flag", los_flag, 1'b0);
        m_last = 0;
        m_run  = 0;
        rst    = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1A5E_0C3D));
        @(posedge clk); #2;
        do_reset();

        // R9: first mark after reset is not accused even if positive twice later
        step(1, 0, "R9", 0);
        // R4: alternating marks with spaces between
        step(0, 0, "R4", 0);
        step(0, 1, "R4", 0);
        step(0, 0, "R4", 0);
        step(0, 0, "R4", 0);
        step(1, 0, "R4", 0);
        step(0, 1, "R4", 0);
        // R3: repeated negative, then repeated across spaces
        step(0, 1, "R3", 0);
        step(0, 0, "R3", 0);
        step(0, 0, "R3", 0);
        step(0, 1, "R3", 0);
        step(1, 0, "R3", 0);
        step(1, 0, "R3", 0);
        // R5: doubled mark clears polarity memory
        step(1, 1, "R5", 0);
        step(1, 0, "R5", 0);
        step(1, 0, "R5", 0);
        // R8: 31 spaces then a mark
        for (int i = 0; i < LOS_N - 1; i++) step(0, 0, "R8", 0);
        step(0, 1, "R8", 0);
        // R6/R7: 32 spaces, more spaces, then a mark
        for (int i = 0; i < LOS_N; i++) step(0, 0, "R6", 0);
        for (int i = 0; i < 5; i++) step(0, 0, "R6", 0);
        step(1, 0, "R7", 0);
        step(0, 0, "R7", 0);
        // R1: rails corrupted between the sampling edges
        step(0, 1, "R1", 1);
        step(0, 1, "R1", 1);
        step(0, 0, "R1", 1);
        step(1, 0, "R1", 1);
        step(1, 1, "R1", 1);
        // R9: reset in the middle of a space run and after a positive mark
        step(1, 0, "R9", 0);
        for (int i = 0; i < 20; i++) step(0, 0, "R9", 0);
        do_reset();
        step(1, 0, "R9", 0);
        for (int i = 0; i < 20; i++) step(0, 0, "R9", 0);
        step(1, 0, "R9", 0);
        // R5: tied rails behave as NRZ with no violation
        for (int i = 0; i < 300; i++) begin
            logic b = $urandom_range(0, 1) != 0;
            step(b, b, "R5", 0);
        end
        // Random AMI-like traffic, dense and sparse phases
        for (int ph = 0; ph < 6; ph++) begin
            int density = (ph % 2 == 0) ? 2 : 45;
            for (int i = 0; i < 400; i++) begin
                logic p, n;
                if ($urandom_range(0, density - 1) == 0 || density == 2 && $urandom_range(0, 1) == 0) begin
                    int k = $urandom_range(0, 9);
                    p = (k < 5) || (k == 9);
                    n = (k >= 5);
                end else begin
                    p = 1'b0;
                    n = 1'b0;
                end
                step(p, n, "R3 R6 R7", (i % 7) == 3);
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule